// File: doc/BRIEF.md
# Coincidence Trigger Unit

This block turns six per-chip fast-OR hit lines and one external trigger line into a single trigger pulse one clock wide. The hit lines form three pairs: pair A is lines 0 and 1, pair B is lines 2 and 3, pair C is lines 4 and 5. Each line can be masked. A mode value then picks the trigger source. It is either the plain OR of all unmasked lines or a coincidence in which two or three pair ORs must be high together. All lines are synchronized, and only a rising edge of the combined level counts as a trigger request.

Each accepted request is held for a programmable delay. The pulse is then issued, and a 16-bit hold-off counter starts. While that counter runs, new requests are refused, which caps the trigger rate. Requests that are refused are counted. Delay and hold-off both count prescaler ticks, and a tick occurs once every `TICK_DIV` clocks. Software sets everything up through a byte-wide write port.

Top module: `coinc_trig_unit`

## Requirements
- R1: After reset, `trig_out` is 0 and `drop_count` is 0. Also after reset: no line is masked, the mode is 0, the internal hit path is off, the external line is on, and delay and hold-off are both 0.
- R2: The internal hit path is on only while bit 0 of register 0x82 is 1. While that bit is 0, activity on the hit lines never produces a pulse.
- R3: In mode 0 (register 0x80), a rising edge of any single unmasked line gives one pulse. With a delay of 0 and `TICK_DIV`=1, the pulse is high in the third clock cycle after the input goes high. With the default two synchronizer stages, this means `trig_out` is sampled high 3 rising edges after the input rises.
- R4: Mode 1 requires A and B together. Mode 2 requires A and C. Mode 3 requires B and C. Mode 4 requires all three of A, B and C. Each pair's term is the OR of its two masked lines. One pair alone never triggers in modes 1 to 4.
- R5: Mode values 5 to 255 never produce a pulse from the hit lines.
- R6: Three mask registers cover the pairs: 0x04 for pair A, 0x14 for pair B and 0x24 for pair C. In each mask register, bit 0 masks the lower-numbered line of the pair and bit 1 masks the higher one. A masked line counts as 0.
- R7: Only a rising edge of the trigger source counts as a request, so a line held high gives exactly one pulse. `trig_out` is never high for two clocks in a row.
- R8: A rising edge on `ext_trig_in` gives a pulse whether or not the internal path is on. Writing bit 0 of register 0x83 as 1 blocks the external line.
- R9: The trigger delay D is a 16-bit value: the low byte is at 0x50 and the high byte at 0x51. D adds D ticks between the request and the pulse, so with `TICK_DIV`=1 the latency of R3 becomes 3+D.
- R10: The hold-off H is a 16-bit value: the low byte is at 0x60 and the high byte at 0x61. Take the case where delay is 0, `TICK_DIV`=1, and a request was accepted from an input edge at cycle t. A second input edge at cycle t+H is dropped. A second edge at cycle t+H+1 is accepted.
- R11: A request is dropped if it arrives during hold-off, while an earlier request is still waiting out its delay, or while a pulse is being driven. Each dropped request raises `drop_count` by exactly 1 and gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| fast_or_in | input | 6 | Per-chip fast-OR hit lines, asynchronous |
| ext_trig_in | input | 1 | External trigger line, asynchronous |
| trig_out | output | 1 | Trigger pulse, one clock wide |
| drop_count | output | DROP_W | Count of dropped requests (saturates) |

## Verification
The assertions assume that the configuration is not rewritten while a request is waiting out its delay. They also assume that `drop_count` never reaches its saturation limit, since the one-step check would not hold there. The bench writes registers only when the block is idle. Before each scenario it waits long enough for any delay and hold-off to run out, and it causes only a few dozen drops in total. Each input level is held for at least two clocks so that the synchronizers see every edge.

// File: rtl/coinc_trig_pkg.sv
package coinc_trig_pkg;
   localparam logic [7:0] ADDR_MASK_A  = 8'h04;
   localparam logic [7:0] ADDR_MASK_B  = 8'h14;
   localparam logic [7:0] ADDR_MASK_C  = 8'h24;
   localparam logic [7:0] ADDR_DLY_LO  = 8'h50;
   localparam logic [7:0] ADDR_DLY_HI  = 8'h51;
   localparam logic [7:0] ADDR_HOLD_LO = 8'h60;
   localparam logic [7:0] ADDR_HOLD_HI = 8'h61;
   localparam logic [7:0] ADDR_MODE    = 8'h80;
   localparam logic [7:0] ADDR_INT_EN  = 8'h82;
   localparam logic [7:0] ADDR_EXT_DIS = 8'h83;

   localparam int N_PAIRS = 3;
   localparam int N_LINES = 2 * N_PAIRS;
   localparam int CNT_W   = 16;

   localparam logic [7:0] MODE_ANY = 8'd0;
   localparam logic [7:0] MODE_AB  = 8'd1;
   localparam logic [7:0] MODE_AC  = 8'd2;
   localparam logic [7:0] MODE_BC  = 8'd3;
   localparam logic [7:0] MODE_ABC = 8'd4;

   typedef enum logic {ST_IDLE, ST_WAIT} seq_state_t;

   typedef struct packed {
      logic [N_LINES-1:0] mask;
      logic [7:0]         mode;
      logic               int_en;
      logic               ext_dis;
      logic [CNT_W-1:0]   delay;
      logic [CNT_W-1:0]   hold;
   } cfg_t;
endpackage

// File: rtl/coinc_cfg_regs.sv
module coinc_cfg_regs
   import coinc_trig_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_addr,
   input  logic [7:0] wr_data,
   output cfg_t       cfg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_MASK_A:  cfg.mask[1:0]   <= wr_data[1:0];
            ADDR_MASK_B:  cfg.mask[3:2]   <= wr_data[1:0];
            ADDR_MASK_C:  cfg.mask[5:4]   <= wr_data[1:0];
            ADDR_DLY_LO:  cfg.delay[7:0]  <= wr_data;
            ADDR_DLY_HI:  cfg.delay[15:8] <= wr_data;
            ADDR_HOLD_LO: cfg.hold[7:0]   <= wr_data;
            ADDR_HOLD_HI: cfg.hold[15:8]  <= wr_data;
            ADDR_MODE:    cfg.mode        <= wr_data;
            ADDR_INT_EN:  cfg.int_en      <= wr_data[0];
            ADDR_EXT_DIS: cfg.ext_dis     <= wr_data[0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/coinc_sync.sv
module coinc_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("coinc_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/coinc_combine.sv
module coinc_combine
   import coinc_trig_pkg::*;
(
   input  logic [N_LINES-1:0] lvl,
   input  logic [N_LINES-1:0] mask,
   input  logic [7:0]         mode,
   output logic               hit
);
   logic [N_PAIRS-1:0] pair_or;

   generate
      for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
         assign pair_or[p] = |(lvl[2*p +: 2] & ~mask[2*p +: 2]);
      end
   endgenerate

   always_comb begin
      case (mode)
         MODE_ANY: hit = |pair_or;
         MODE_AB:  hit = pair_or[0] & pair_or[1];
         MODE_AC:  hit = pair_or[0] & pair_or[2];
         MODE_BC:  hit = pair_or[1] & pair_or[2];
         MODE_ABC: hit = &pair_or;
         default:  hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/coinc_seq.sv
module coinc_seq
   import coinc_trig_pkg::*;
#(
   parameter int TICK_DIV = 1,
   parameter int DROP_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [CNT_W-1:0]  delay,
   input  logic [CNT_W-1:0]  hold,
   output logic              trig_out,
   output logic [DROP_W-1:0] drop_count,
   output logic [CNT_W-1:0]  hold_cnt,
   output logic              waiting
);
   localparam int PS_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   logic             tick;
   seq_state_t       state;
   logic [CNT_W-1:0] dly_cnt;
   logic             busy, accept, fire;

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("coinc_seq: TICK_DIV must be at least 1");
      end
      if (TICK_DIV == 1) begin : g_tick_every
         assign tick = 1'b1;
      end else begin : g_tick_div
         logic [PS_W-1:0] ps_cnt;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)                           ps_cnt <= '0;
            else if (ps_cnt == PS_W'(TICK_DIV-1)) ps_cnt <= '0;
            else                                  ps_cnt <= ps_cnt + PS_W'(1);
         assign tick = (ps_cnt == PS_W'(TICK_DIV-1));
      end
   endgenerate

   assign busy    = (state != ST_IDLE) || (hold_cnt != '0) || trig_out;
   assign accept  = req && !busy;
   assign fire    = (accept && (delay == '0)) ||
                    ((state == ST_WAIT) && tick && (dly_cnt == CNT_W'(1)));
   assign waiting = (state == ST_WAIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         dly_cnt    <= '0;
         hold_cnt   <= '0;
         trig_out   <= 1'b0;
         drop_count <= '0;
      end else begin
         trig_out <= fire;
         if (req && busy && (drop_count != '1))
            drop_count <= drop_count + DROP_W'(1);
         if (accept && (delay != '0)) begin
            state   <= ST_WAIT;
            dly_cnt <= delay;
         end else if ((state == ST_WAIT) && tick) begin
            if (dly_cnt == CNT_W'(1)) state <= ST_IDLE;
            dly_cnt <= dly_cnt - CNT_W'(1);
         end
         if (fire)                          hold_cnt <= hold;
         else if (tick && (hold_cnt != '0)) hold_cnt <= hold_cnt - CNT_W'(1);
      end
   end
endmodule

// File: rtl/coinc_trig_unit.sv
module coinc_trig_unit
   import coinc_trig_pkg::*;
#(
   parameter int TICK_DIV    = 1,
   parameter int SYNC_STAGES = 2,
   parameter int DROP_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [5:0]        fast_or_in,
   input  logic              ext_trig_in,
   output logic              trig_out,
   output logic [DROP_W-1:0] drop_count
);
   cfg_t               cfg;
   logic [N_LINES-1:0] lines_s;
   logic               ext_s, ext_q, hit, hit_q, req;
   logic [CNT_W-1:0]   hold_cnt;
   logic               waiting;

   generate
      if (DROP_W < 1) begin : g_bad_drop
         $error("coinc_trig_unit: DROP_W must be at least 1");
      end
   endgenerate

   coinc_cfg_regs i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .cfg(cfg)
   );

   coinc_sync #(.W(N_LINES + 1), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ext_trig_in, fast_or_in}), .q({ext_s, lines_s})
   );

   coinc_combine i_comb (
      .lvl(lines_s), .mask(cfg.mask), .mode(cfg.mode), .hit(hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         ext_q <= 1'b0;
      end else begin
         hit_q <= hit;
         ext_q <= ext_s;
      end
   end

   assign req = (hit && !hit_q && cfg.int_en) || (ext_s && !ext_q && !cfg.ext_dis);

   coinc_seq #(.TICK_DIV(TICK_DIV), .DROP_W(DROP_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .req(req),
      .delay(cfg.delay), .hold(cfg.hold),
      .trig_out(trig_out), .drop_count(drop_count),
      .hold_cnt(hold_cnt), .waiting(waiting)
   );
endmodule

// File: rtl/coinc_trig_chk.sv
module coinc_trig_chk #(
   parameter int DROP_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trig_out,
   input logic [DROP_W-1:0] drop_count,
   input logic [15:0]       hold_cnt,
   input logic [7:0]        mode,
   input logic              hit,
   input logic              waiting
);
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |=> !trig_out); // R7

   AST_FIRE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> ($past(hold_cnt) == 16'd0)); // R10

   AST_WAIT_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      waiting |-> (hold_cnt == 16'd0)); // R10

   AST_UNLISTED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode > 8'd4) |-> !hit); // R5

   AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((drop_count == $past(drop_count)) ||
                (drop_count == DROP_W'($past(drop_count) + 1'b1)))); // R11
endmodule

bind coinc_trig_unit coinc_trig_chk #(.DROP_W(DROP_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .trig_out(trig_out), .drop_count(drop_count),
   .hold_cnt(hold_cnt), .mode(cfg.mode), .hit(hit), .waiting(waiting)
);

// File: tb/test_coinc_trig_unit.sv
module test_coinc_trig_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [5:0]  fast_or_in = '0;
   logic        ext_trig_in = 1'b0;
   logic        trig_out;
   logic [15:0] drop_count;

   int cyc = 0;
   int pulses = 0;
   int last_pulse = -1;
   int wide = 0;
   logic prev_trig = 1'b0;
   int n_checks = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   coinc_trig_unit i_coinc_trig_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .fast_or_in(fast_or_in), .ext_trig_in(ext_trig_in),
      .trig_out(trig_out), .drop_count(drop_count)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (trig_out) begin
         pulses++;
         last_pulse = cyc;
      end
      if (trig_out && prev_trig) wide++;
      prev_trig = trig_out;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic stim(input logic [5:0] lines, input logic ext, input int hold,
                       input int settle, output int t);
      @(negedge clk);
      t = cyc;
      fast_or_in = lines; ext_trig_in = ext;
      repeat (hold) @(negedge clk);
      fast_or_in = '0; ext_trig_in = 1'b0;
      repeat (settle) @(negedge clk);
   endtask

   task automatic expect_one(input string req, input int n0, input int t, input int lat);
      chk(pulses == n0 + 1, req, pulses - n0, 1);
      chk(last_pulse - t == lat, req, last_pulse - t, lat);
   endtask

   task automatic expect_none(input string req, input int n0);
      chk(pulses == n0, req, pulses - n0, 0);
   endtask

   task automatic t_reset();
      int n0, t;
      chk(trig_out == 1'b0, "R1 trig_out", trig_out, 0);
      chk(drop_count == 16'd0, "R1 drop_count", drop_count, 0);
      n0 = pulses;
      stim(6'b000001, 1'b0, 3, 8, t);
      expect_none("R1 R2 internal path off after reset", n0);
   endtask

   task automatic t_or_mode();
      int n0, t;
      wr(8'h82, 8'h01);
      for (int i = 0; i < 6; i++) begin
         n0 = pulses;
         stim(6'(1 << i), 1'b0, 3, 8, t);
         expect_one("R3 single line", n0, t, 3);
      end
      wr(8'h82, 8'h00);
      n0 = pulses;
      stim(6'b111111, 1'b0, 3, 8, t);
      expect_none("R2 internal path disabled", n0);
      wr(8'h82, 8'h01);
   endtask

   task automatic t_held();
      int n0, t;
      n0 = pulses;
      stim(6'b000100, 1'b0, 30, 8, t);
      expect_one("R7 held line", n0, t, 3);
      chk(wide == 0, "R7 pulse width", wide, 0);
   endtask

   task automatic try_mode(input logic [7:0] mode, input logic [5:0] lines,
                           input bit exp, input string req);
      int n0, t;
      wr(8'h80, mode);
      n0 = pulses;
      stim(lines, 1'b0, 3, 8, t);
      if (exp) expect_one(req, n0, t, 3);
      else     expect_none(req, n0);
   endtask

   task automatic t_coinc();
      try_mode(8'd1, 6'b000001, 1'b0, "R4 mode1 A alone");
      try_mode(8'd1, 6'b000101, 1'b1, "R4 mode1 A and B");
      try_mode(8'd1, 6'b110000, 1'b0, "R4 mode1 C only");
      try_mode(8'd2, 6'b100010, 1'b1, "R4 mode2 A and C");
      try_mode(8'd2, 6'b000101, 1'b0, "R4 mode2 A and B");
      try_mode(8'd3, 6'b011000, 1'b1, "R4 mode3 B and C");
      try_mode(8'd3, 6'b100001, 1'b0, "R4 mode3 A and C");
      try_mode(8'd4, 6'b000101, 1'b0, "R4 mode4 A and B");
      try_mode(8'd4, 6'b011010, 1'b1, "R4 mode4 all pairs");
      try_mode(8'd5, 6'b111111, 1'b0, "R5 mode5");
      try_mode(8'd255, 6'b111111, 1'b0, "R5 mode255");
      wr(8'h80, 8'd0);
   endtask

   task automatic t_mask();
      int n0, t;
      wr(8'h04, 8'h01);
      n0 = pulses; stim(6'b000001, 1'b0, 3, 8, t); expect_none("R6 mask A bit0", n0);
      n0 = pulses; stim(6'b000010, 1'b0, 3, 8, t); expect_one("R6 A line1 open", n0, t, 3);
      wr(8'h24, 8'h02);
      n0 = pulses; stim(6'b100000, 1'b0, 3, 8, t); expect_none("R6 mask C bit1", n0);
      n0 = pulses; stim(6'b010000, 1'b0, 3, 8, t); expect_one("R6 C line4 open", n0, t, 3);
      wr(8'h14, 8'h03);
      n0 = pulses; stim(6'b001100, 1'b0, 3, 8, t); expect_none("R6 mask B both", n0);
      wr(8'h04, 8'h00); wr(8'h14, 8'h00); wr(8'h24, 8'h00);
   endtask

   task automatic t_ext();
      int n0, t;
      wr(8'h82, 8'h00);
      n0 = pulses; stim(6'b0, 1'b1, 3, 8, t); expect_one("R8 external edge", n0, t, 3);
      wr(8'h83, 8'h01);
      n0 = pulses; stim(6'b0, 1'b1, 3, 8, t); expect_none("R8 external blocked", n0);
      wr(8'h83, 8'h00);
      wr(8'h82, 8'h01);
   endtask

   task automatic t_delay();
      int n0, t;
      wr(8'h50, 8'd5);
      n0 = pulses; stim(6'b000001, 1'b0, 3, 15, t); expect_one("R9 delay 5", n0, t, 8);
      wr(8'h50, 8'd0); wr(8'h51, 8'd1);
      n0 = pulses; stim(6'b000001, 1'b0, 3, 270, t); expect_one("R9 delay 256", n0, t, 259);
      wr(8'h51, 8'd0);
   endtask

   task automatic hold_pair(input int gap, input bit exp_second);
      int n0, d0, t;
      n0 = pulses; d0 = drop_count;
      @(negedge clk);
      t = cyc;
      ext_trig_in = 1'b1;
      repeat (gap) @(negedge clk);
      fast_or_in = 6'b000001;
      repeat (3) @(negedge clk);
      fast_or_in = '0; ext_trig_in = 1'b0;
      repeat (25) @(negedge clk);
      if (exp_second) begin
         chk(pulses == n0 + 2, "R10 accepted after hold-off", pulses - n0, 2);
         chk(last_pulse - t == gap + 3, "R10 second pulse time", last_pulse - t, gap + 3);
         chk(drop_count == 16'(d0), "R11 no drop", drop_count, d0);
      end else begin
         chk(pulses == n0 + 1, "R10 dropped in hold-off", pulses - n0, 1);
         chk(drop_count == 16'(d0 + 1), "R11 drop counted", drop_count, d0 + 1);
      end
   endtask

   task automatic t_hold();
      wr(8'h60, 8'd10);
      hold_pair(10, 1'b0);
      hold_pair(11, 1'b1);
      wr(8'h60, 8'd0);
   endtask

   task automatic t_drop_delay();
      int n0, d0, t;
      wr(8'h50, 8'd20);
      n0 = pulses; d0 = drop_count;
      @(negedge clk);
      t = cyc;
      fast_or_in = 6'b000001;
      repeat (5) @(negedge clk);
      ext_trig_in = 1'b1;
      repeat (3) @(negedge clk);
      fast_or_in = '0; ext_trig_in = 1'b0;
      repeat (40) @(negedge clk);
      expect_one("R11 drop while delaying", n0, t, 23);
      chk(drop_count == 16'(d0 + 1), "R11 drop during delay", drop_count, d0 + 1);
      wr(8'h50, 8'd0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_or_mode();
      t_held();
      t_coinc();
      t_mask();
      t_ext();
      t_delay();
      t_hold();
      t_drop_delay();
      chk(wide == 0, "R7 no wide pulse overall", wide, 0);
      summary();
      $finish;
   end
endmodule